// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block is a fully associative translation buffer that serves instruction and data translation from one array. Every entry covers a pair of adjacent virtual pages, an even one and an odd one. It holds one virtual tag for the pair, an address-space number, a global flag and a page-size code. It also holds two frame records, each with a physical frame number, valid and dirty bits and a three-bit cache attribute.

A lookup is purely combinational. The address, address-space number and a store flag go in, and in the same cycle the block returns the physical address, hit, miss and multiple-match flags, the frame attribute and two fault flags. The physical tag is therefore ready while a cache is still being indexed. Entries are loaded one at a time through a write port that takes an index and a whole entry record. A write takes effect on the clock edge that samples the strobe.

Top module: `tlb_pair_xlate`

## Requirements
- R1: After reset, and before any write, every lookup misses.
- R2: A write with `wr_en` high replaces every field of entry `wr_idx` at the clock edge that samples it. A lookup in the very next cycle already sees the new contents, and the old contents no longer match.
- R3: The size code k (0 to 6) gives a page of 4 KB times 4^k, with a page offset of 12+2k bits. The tag compare uses virtual address bits 13+2k and above. The low 2k bits of the stored tag are ignored.
- R4: An entry matches only if its tag matches and either its global flag is set or its address-space number equals `lk_asid`.
- R5: Virtual address bit 12+2k selects the frame: 0 selects the even frame and 1 selects the odd frame. The physical address takes the frame bits above the page offset and the virtual address bits within it.
- R6: On a hit to a valid frame, `lk_attr` carries that frame's attribute.
- R7: A hit on a frame whose valid bit is clear raises `lk_fault_inv`. In that case `lk_pa` and `lk_attr` are zero and `lk_fault_mod` stays low.
- R8: A store lookup that hits a valid frame with its dirty bit clear raises `lk_fault_mod`. A load, or a store to a dirty frame, raises no fault.
- R9: On a miss, `lk_miss` is 1 and `lk_hit` is 0. `lk_pa`, `lk_attr` and both fault flags are zero.
- R10: When more than one entry matches, `lk_multi` is 1 and the entry with the lowest index supplies the result.
- R11: A write whose index is not below ENTRIES changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, empties the array |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Lookup address-space number |
| lk_store | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | An entry matched |
| lk_miss | output | 1 | No entry matched |
| lk_multi | output | 1 | More than one entry matched |
| lk_pa | output | PA_W | Physical address |
| lk_attr | output | 3 | Attribute of the selected frame |
| lk_fault_inv | output | 1 | Hit on an invalid frame |
| lk_fault_mod | output | 1 | Store to a clean frame |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vpn2 | input | VA_W-13 | Tag of the page pair (virtual address bits 13 and up) |
| wr_asid | input | ASID_W | Address-space number |
| wr_global | input | 1 | Global flag |
| wr_size | input | 3 | Page-size code |
| wr_pfn_e | input | PA_W-12 | Even frame number |
| wr_valid_e | input | 1 | Even frame valid |
| wr_dirty_e | input | 1 | Even frame dirty |
| wr_attr_e | input | 3 | Even frame attribute |
| wr_pfn_o | input | PA_W-12 | Odd frame number |
| wr_valid_o | input | 1 | Odd frame valid |
| wr_dirty_o | input | 1 | Odd frame dirty |
| wr_attr_o | input | 3 | Odd frame attribute |

## Verification
The bench builds the block with ENTRIES=6 and keeps the other defaults: a 40-bit virtual address, a 36-bit physical address and an 8-bit address-space number. With only six entries, a three-bit index reaches values 6 and 7, so writes that fall outside the array can be tested, and the last entry is easy to target. The default address widths allow every size from 4 KB up to 16 MB, so the smallest, a middle and the largest page size are each checked for frame selection and for ignoring the low tag bits.

// File: rtl/tlb_pair_xlate.sv
module tlb_pair_xlate #(
  parameter int ENTRIES = 48,
  parameter int VA_W    = 40,
  parameter int PA_W    = 36,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int VPN_W  = VA_W - 13,
  localparam int PFN_W  = PA_W - 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_store,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_multi,
  output logic [PA_W-1:0]   lk_pa,
  output logic [2:0]        lk_attr,
  output logic              lk_fault_inv,
  output logic              lk_fault_mod,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [2:0]        wr_size,
  input  logic [PFN_W-1:0]  wr_pfn_e,
  input  logic              wr_valid_e,
  input  logic              wr_dirty_e,
  input  logic [2:0]        wr_attr_e,
  input  logic [PFN_W-1:0]  wr_pfn_o,
  input  logic              wr_valid_o,
  input  logic              wr_dirty_o,
  input  logic [2:0]        wr_attr_o
);

  logic              live   [ENTRIES];
  logic [VPN_W-1:0]  vpn2   [ENTRIES];
  logic [ASID_W-1:0] asid   [ENTRIES];
  logic              glob   [ENTRIES];
  logic [2:0]        size   [ENTRIES];
  logic [PFN_W-1:0]  pfn    [ENTRIES][2];
  logic              fvalid [ENTRIES][2];
  logic              fdirty [ENTRIES][2];
  logic [2:0]        fattr  [ENTRIES][2];
  logic [ENTRIES-1:0] match;

  function automatic logic [2:0] clamp_size(input logic [2:0] s);
    return (s == 3'd7) ? 3'd6 : s;
  endfunction

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [VPN_W-1:0] ign;
    assign ign = (VPN_W'(1) << (2 * clamp_size(size[i]))) - VPN_W'(1);
    assign match[i] = live[i] && (((lk_va[VA_W-1:13] ^ vpn2[i]) & ~ign) == '0)
                      && (glob[i] || asid[i] == lk_asid);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live[i] <= 1'b0;
        vpn2[i] <= '0;
        asid[i] <= '0;
        glob[i] <= 1'b0;
        size[i] <= '0;
        for (int s = 0; s < 2; s++) begin
          pfn[i][s]    <= '0;
          fvalid[i][s] <= 1'b0;
          fdirty[i][s] <= 1'b0;
          fattr[i][s]  <= '0;
        end
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        live[i]      <= 1'b1;
        vpn2[i]      <= wr_vpn2;
        asid[i]      <= wr_asid;
        glob[i]      <= wr_global;
        size[i]      <= wr_size;
        pfn[i][0]    <= wr_pfn_e;
        fvalid[i][0] <= wr_valid_e;
        fdirty[i][0] <= wr_dirty_e;
        fattr[i][0]  <= wr_attr_e;
        pfn[i][1]    <= wr_pfn_o;
        fvalid[i][1] <= wr_valid_o;
        fdirty[i][1] <= wr_dirty_o;
        fattr[i][1]  <= wr_attr_o;
      end
    end
  end

  logic [IDX_W-1:0] sel;
  logic             any, many;

  always_comb begin
    any  = 1'b0;
    many = 1'b0;
    sel  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        if (any) many = 1'b1;
        else begin
          any = 1'b1;
          sel = IDX_W'(i);
        end
      end
    end
  end

  logic [5:0]      off_bits;
  logic            side;
  logic [PA_W-1:0] off_mask, frame_base;
  logic            f_ok;

  assign off_bits   = 6'd12 + (6'(clamp_size(size[sel])) << 1);
  assign side       = lk_va[off_bits];
  assign off_mask   = (PA_W'(1) << off_bits) - PA_W'(1);
  assign frame_base = {pfn[sel][side], 12'b0};
  assign f_ok       = any && fvalid[sel][side];

  assign lk_hit       = any;
  assign lk_miss      = !any;
  assign lk_multi     = many;
  assign lk_pa        = f_ok ? ((frame_base & ~off_mask) | (lk_va[PA_W-1:0] & off_mask)) : '0;
  assign lk_attr      = f_ok ? fattr[sel][side] : 3'd0;
  assign lk_fault_inv = any && !fvalid[sel][side];
  assign lk_fault_mod = f_ok && lk_store && !fdirty[sel][side];

  a_r9_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit != lk_miss);
  a_r9_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_pa == '0 && lk_attr == 3'd0 && !lk_fault_inv && !lk_fault_mod));
  a_r7_inv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault_inv |-> (lk_pa == '0 && lk_attr == 3'd0 && !lk_fault_mod));
  a_r8_mod_store: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault_mod |-> (lk_store && lk_hit));
  a_r10_multi_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit);
  a_r1_reset_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> lk_miss);

endmodule

// File: tb/tb_tlb_pair_xlate.sv
module tb_tlb_pair_xlate;
  localparam int ENTRIES = 6;
  localparam int VA_W = 40, PA_W = 36, ASID_W = 8;
  localparam int IDX_W = 3, VPN_W = VA_W - 13, PFN_W = PA_W - 12;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [VA_W-1:0] lk_va = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic lk_store = 1'b0;
  logic lk_hit, lk_miss, lk_multi, lk_fault_inv, lk_fault_mod;
  logic [PA_W-1:0] lk_pa;
  logic [2:0] lk_attr;
  logic wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [VPN_W-1:0] wr_vpn2 = '0;
  logic [ASID_W-1:0] wr_asid = '0;
  logic wr_global = 1'b0;
  logic [2:0] wr_size = '0;
  logic [PFN_W-1:0] wr_pfn_e = '0, wr_pfn_o = '0;
  logic wr_valid_e = 1'b0, wr_dirty_e = 1'b0, wr_valid_o = 1'b0, wr_dirty_o = 1'b0;
  logic [2:0] wr_attr_e = '0, wr_attr_o = '0;

  tlb_pair_xlate #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) dut (.*);

  typedef struct {
    logic hit, multi, finv, fmod;
    logic [PA_W-1:0] pa;
    logic [2:0] attr;
    string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic wr(input int idx, input logic [VPN_W-1:0] v, input int as, input bit g,
                    input int sz, input logic [PFN_W-1:0] pe, input bit ve, input bit de,
                    input int ae, input logic [PFN_W-1:0] po, input bit vo, input bit dd,
                    input int ao);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_vpn2 = v; wr_asid = ASID_W'(as);
    wr_global = g; wr_size = 3'(sz);
    wr_pfn_e = pe; wr_valid_e = ve; wr_dirty_e = de; wr_attr_e = 3'(ae);
    wr_pfn_o = po; wr_valid_o = vo; wr_dirty_o = dd; wr_attr_o = 3'(ao);
  endtask

  task automatic look(input logic [VA_W-1:0] va, input int as, input bit st,
                      input bit h, input bit m, input bit fi, input bit fm,
                      input logic [PA_W-1:0] pa, input int at, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = 1'b0;
    lk_va = va; lk_asid = ASID_W'(as); lk_store = st;
    e.hit = h; e.multi = m; e.finv = fi; e.fmod = fm; e.pa = pa; e.attr = 3'(at); e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #3;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (lk_hit !== e.hit || lk_miss !== !e.hit || lk_multi !== e.multi ||
            lk_fault_inv !== e.finv || lk_fault_mod !== e.fmod ||
            lk_pa !== e.pa || lk_attr !== e.attr) begin
          fails++;
          $display("FAIL %s: got hit=%b miss=%b multi=%b inv=%b mod=%b pa=%h attr=%0d, expected hit=%b multi=%b inv=%b mod=%b pa=%h attr=%0d",
                   e.tag, lk_hit, lk_miss, lk_multi, lk_fault_inv, lk_fault_mod, lk_pa, lk_attr,
                   e.hit, e.multi, e.finv, e.fmod, e.pa, e.attr);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    look(40'h0, 0, 0, 0, 0, 0, 0, '0, 0, "R1 empty after reset");
    look(40'h4123, 5, 0, 0, 0, 0, 0, '0, 0, "R1 empty after reset");
    // entry 0: 4 KB pair at 0x4000, asid 5
    wr(0, 27'h2, 5, 0, 0, 24'h100, 1, 1, 3, 24'h200, 1, 0, 2);
    look(40'h4123, 5, 0, 1, 0, 0, 0, 36'h100123, 3, "R2 next-cycle visibility R5 even R6");
    look(40'h5ABC, 5, 1, 1, 0, 0, 1, 36'h200ABC, 2, "R8 store to clean odd frame");
    look(40'h5ABC, 5, 0, 1, 0, 0, 0, 36'h200ABC, 2, "R8 load to clean frame");
    look(40'h4FFF, 5, 1, 1, 0, 0, 0, 36'h100FFF, 3, "R8 store to dirty frame");
    look(40'h4123, 6, 0, 0, 0, 0, 0, '0, 0, "R4 asid mismatch R9");
    look(40'h6123, 5, 0, 0, 0, 0, 0, '0, 0, "R3 4KB tag mismatch R9");
    // entry 1: 16 MB global pair, low stored tag bits set
    wr(1, 27'h500FFF, 0, 1, 6, 24'h3005, 1, 1, 6, 24'h4000, 0, 0, 7);
    look(40'hA00123456, 9, 0, 1, 0, 0, 0, 36'h3123456, 6, "R3 16MB low tag bits ignored R5");
    look(40'hA01000010, 9, 0, 1, 0, 1, 0, '0, 0, "R7 invalid odd frame R5");
    look(40'hA01000010, 9, 1, 1, 0, 1, 0, '0, 0, "R7 store to invalid frame");
    look(40'hA02000010, 9, 0, 0, 0, 0, 0, '0, 0, "R3 16MB next pair misses");
    // entry 2: 64 KB pair at 0x60000
    wr(2, 27'h33, 2, 0, 2, 24'h777, 1, 1, 1, 24'hABC, 1, 1, 5);
    look(40'h71234, 2, 1, 1, 0, 0, 0, 36'hAB1234, 5, "R3 64KB R5 odd select R6");
    look(40'h60010, 2, 0, 1, 0, 0, 0, 36'h770010, 1, "R5 64KB even select");
    // entry 3: global duplicate of entry 0 tag
    wr(3, 27'h2, 0, 1, 0, 24'h999, 1, 1, 4, 24'h999, 1, 1, 4);
    look(40'h4123, 5, 0, 1, 1, 0, 0, 36'h100123, 3, "R10 lowest index wins");
    look(40'h4123, 7, 0, 1, 0, 0, 0, 36'h999123, 4, "R4 global ignores asid");
    wr(3, 27'h7777, 0, 0, 0, 24'h1, 1, 1, 0, 24'h1, 1, 1, 0);
    look(40'h4123, 5, 0, 1, 0, 0, 0, 36'h100123, 3, "R2 replaced entry no longer matches");
    look(40'h4123, 7, 0, 0, 0, 0, 0, '0, 0, "R2 old global mapping gone");
    // out-of-range writes
    wr(7, 27'h10000, 5, 1, 0, 24'h55, 1, 1, 1, 24'h55, 1, 1, 1);
    look(40'h20000000, 5, 0, 0, 0, 0, 0, '0, 0, "R11 index 7 ignored");
    wr(6, 27'h10000, 5, 1, 0, 24'h55, 1, 1, 1, 24'h55, 1, 1, 1);
    look(40'h20000000, 5, 0, 0, 0, 0, 0, '0, 0, "R11 index 6 ignored");
    look(40'h4123, 5, 0, 1, 0, 0, 0, 36'h100123, 3, "R11 existing entry intact");
    wr(5, 27'h10000, 5, 0, 0, 24'h55, 1, 1, 1, 24'h66, 1, 1, 2);
    look(40'h20000ABC, 5, 0, 1, 0, 0, 0, 36'h55ABC, 1, "R2 last entry written");
    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule